// File: doc/BRIEF.md
# Six-Source Nested Priority Interrupt Arbiter

This block decides which of six interrupt sources a small 8-bit CPU core services next. Each source is gated first by a global enable and then by its own enable bit. It is then given one of four priority levels, formed from one bit in a high-priority register and one bit in a low-priority register. On every machine-cycle tick the arbiter finds the eligible request with the highest level and breaks ties within that level with a fixed polling order.

The block keeps one in-service bit for each priority level. A winning request is passed to the core only if its level is strictly above the highest level now in service. This lets handlers nest: a low-level handler can be preempted by a higher level, while a level-3 handler cannot be preempted. When a vector is issued, the block raises a one-cycle request strobe carrying a 3-bit source index and marks the winning level as in service. A return-from-interrupt pulse from the core releases the highest in-service level.

The raw flags come from the peripherals. The serial source is the OR of its receive and transmit flags, and the timer 2 source is the OR of its overflow and external-capture flags. Detecting edges on the pins and clearing flags are done elsewhere.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the strobe `irq_o` is low, `vec_o` is 0 and no level is in service, so the first eligible request of any level is accepted.
- R2: While `ie_all_i` is 0, no vector is issued, whatever flags and per-source enables are set.
- R3: While `ie_all_i` is 1, source i is eligible only if `ie_src_i[i]` is 1. The index order is 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2.
- R4: `flags_i` bits 0..3 drive sources 0..3 directly. Source 4 is requested by bit 4 (receive) OR bit 5 (transmit). Source 5 is requested by bit 6 (overflow) OR bit 7 (capture).
- R5: The level of source i is {`pri_hi_i[i]`, `pri_lo_i[i]`} (0 to 3, 3 highest). Among requests in the same tick, the highest level wins.
- R6: Among requests at the same winning level, the lowest source index wins.
- R7: A request is issued only if its level is strictly above the highest in-service level. Requests at the same or a lower level wait, and nothing preempts level 3.
- R8: A pulse on `reti_i` clears the highest in-service level only. After that, a waiting request above the remaining in-service level (or any request if none remain) is issued on the next tick.
- R9: Requests are sampled only in cycles where `tick_i` is 1. A vector issued at a tick raises `irq_o` for exactly the next clock cycle, with `vec_o` holding the winner's index while `irq_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Machine-cycle sampling tick |
| flags_i | input | 8 | Raw interrupt flags (see R4) |
| ie_all_i | input | 1 | Global interrupt enable |
| ie_src_i | input | 6 | Per-source enables, bit i for source i |
| pri_hi_i | input | 6 | High bit of each source's level |
| pri_lo_i | input | 6 | Low bit of each source's level |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | One-cycle request strobe to the core |
| vec_o | output | 3 | Index of the source issued |

## Verification
The assertions assume the core pulses `reti_i` only while a level is in service, and never in the same cycle as a vector issue. The in-service count check relies on this. The stimulus meets these conditions by spacing every return pulse apart from ticks and by issuing exactly as many returns as vectors accepted in each scenario. The stimulus changes flags, enables and priorities only on falling edges and only while `tick_i` is low. As a result, every sampled request reflects one settled configuration.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   localparam int unsigned IRQ_N_SRC  = 6;
   localparam int unsigned IRQ_N_LVL  = 4;
   localparam int unsigned IRQ_LVL_W  = $clog2(IRQ_N_LVL);
   localparam int unsigned IRQ_IDX_W  = $clog2(IRQ_N_SRC);
   // two shared sources each merge a pair of raw flags
   localparam int unsigned IRQ_N_FLAG = IRQ_N_SRC + 2;
endpackage

// File: rtl/irq_flag_merge.sv
module irq_flag_merge #(
   parameter int unsigned N_SRC  = irq_prio_pkg::IRQ_N_SRC,
   localparam int unsigned N_FLAG = N_SRC + 2
) (
   input  logic [N_FLAG-1:0] flags_i,
   output logic [N_SRC-1:0]  req_o
);
   if (N_SRC < 3) begin : g_bad_src
      $error("irq_flag_merge needs at least three sources");
   end

   // sources below the two merged ones map one flag each
   for (genvar i = 0; i < N_SRC - 2; i++) begin : g_direct
      assign req_o[i] = flags_i[i];
   end
   // serial: receive or transmit
   assign req_o[N_SRC-2] = flags_i[N_SRC-2] | flags_i[N_SRC-1];
   // timer 2: overflow or external capture
   assign req_o[N_SRC-1] = flags_i[N_SRC]   | flags_i[N_SRC+1];
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
   parameter int unsigned N_SRC = irq_prio_pkg::IRQ_N_SRC,
   parameter int unsigned N_LVL = irq_prio_pkg::IRQ_N_LVL,
   localparam int unsigned LVL_W = $clog2(N_LVL),
   localparam int unsigned IDX_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]            elig_i,
   input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
   output logic                        win_vld_o,
   output logic [LVL_W-1:0]            win_lvl_o,
   output logic [IDX_W-1:0]            win_idx_o
);
   if (N_LVL < 2 || (1 << LVL_W) != N_LVL) begin : g_bad_lvl
      $error("irq_level_arb: level count must be a power of two of at least 2");
   end

   // scan from the last polled source towards index 0; ">=" lets
   // an earlier index take over a tie, so polling order breaks ties
   always_comb begin
      win_vld_o = 1'b0;
      win_lvl_o = '0;
      win_idx_o = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (elig_i[i] && (!win_vld_o || lvl_i[i] >= win_lvl_o)) begin
            win_vld_o = 1'b1;
            win_lvl_o = lvl_i[i];
            win_idx_o = IDX_W'(i);
         end
      end
   end

   // R3: a winner is always one of the eligible requests
   always_comb begin
      if (win_vld_o) begin
         p_winner_eligible_r3: assert (elig_i[win_idx_o])
            else $error("winner not eligible");
      end
      // R5: a winner exists exactly when something is eligible
      p_winner_iff_elig_r5: assert (win_vld_o == (|elig_i))
         else $error("winner valid mismatch");
   end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice #(
   parameter int unsigned N_LVL = irq_prio_pkg::IRQ_N_LVL,
   localparam int unsigned LVL_W = $clog2(N_LVL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic [LVL_W-1:0] set_lvl_i,
   input  logic             reti_i,
   output logic             act_vld_o,
   output logic [LVL_W-1:0] act_lvl_o
);
   logic [N_LVL-1:0] busy_q, busy_d, clr_mask, set_mask;

   // highest busy level and the mask that releases it
   always_comb begin
      act_vld_o = 1'b0;
      act_lvl_o = '0;
      clr_mask  = '0;
      for (int l = 0; l < N_LVL; l++) begin
         if (busy_q[l]) begin
            act_vld_o = 1'b1;
            act_lvl_o = LVL_W'(l);
         end
      end
      if (reti_i && act_vld_o) clr_mask[act_lvl_o] = 1'b1;
   end

   always_comb begin
      set_mask = '0;
      if (set_i) set_mask[set_lvl_i] = 1'b1;
      busy_d = (busy_q & ~clr_mask) | set_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) busy_q <= '0;
      else        busy_q <= busy_d;
   end

   // R8: a lone return releases exactly one level
   p_reti_releases_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && act_vld_o && !set_i) |=>
         ($countones(busy_q) == $past($countones(busy_q)) - 1))
      else $error("return did not release one level");

   // R7: nothing is accepted while the top level is in service
   p_top_level_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q[N_LVL-1] |-> !set_i)
      else $error("top level handler preempted");
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int unsigned N_SRC = irq_prio_pkg::IRQ_N_SRC,
   parameter int unsigned N_LVL = irq_prio_pkg::IRQ_N_LVL,
   localparam int unsigned LVL_W  = $clog2(N_LVL),
   localparam int unsigned IDX_W  = $clog2(N_SRC),
   localparam int unsigned N_FLAG = N_SRC + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [N_FLAG-1:0] flags_i,
   input  logic              ie_all_i,
   input  logic [N_SRC-1:0]  ie_src_i,
   input  logic [N_SRC-1:0]  pri_hi_i,
   input  logic [N_SRC-1:0]  pri_lo_i,
   input  logic              reti_i,
   output logic              irq_o,
   output logic [IDX_W-1:0]  vec_o
);
   if (N_LVL != 4) begin : g_bad_levels
      $error("two priority planes give exactly four levels");
   end

   logic [N_SRC-1:0]            req, elig;
   logic [N_SRC-1:0][LVL_W-1:0] src_lvl;
   logic                        win_vld, act_vld, accept;
   logic [LVL_W-1:0]            win_lvl, act_lvl;
   logic [IDX_W-1:0]            win_idx;

   irq_flag_merge #(.N_SRC(N_SRC)) i_merge (
      .flags_i (flags_i),
      .req_o   (req)
   );

   for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
      assign src_lvl[i] = {pri_hi_i[i], pri_lo_i[i]};
   end

   assign elig = req & ie_src_i & {N_SRC{ie_all_i}};

   irq_level_arb #(.N_SRC(N_SRC), .N_LVL(N_LVL)) i_arb (
      .elig_i    (elig),
      .lvl_i     (src_lvl),
      .win_vld_o (win_vld),
      .win_lvl_o (win_lvl),
      .win_idx_o (win_idx)
   );

   assign accept = tick_i && win_vld && (!act_vld || win_lvl > act_lvl);

   irq_inservice #(.N_LVL(N_LVL)) i_isr (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (accept),
      .set_lvl_i (win_lvl),
      .reti_i    (reti_i),
      .act_vld_o (act_vld),
      .act_lvl_o (act_lvl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
         vec_o <= '0;
      end else begin
         irq_o <= accept;
         if (accept) vec_o <= win_idx;
      end
   end

   // R9: a strobe always follows a sampling tick
   p_strobe_after_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(tick_i))
      else $error("strobe without tick");

   // R2: no strobe unless the global enable was set at the tick
   p_global_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(ie_all_i))
      else $error("strobe with global enable clear");

   // R7: every issued vector leaves a level marked in service
   p_level_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> act_vld)
      else $error("vector issued without in-service level");
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] flags = '0;
   logic       ie_all = 1'b0;
   logic [5:0] ie_src = '0;
   logic [5:0] pri_hi = '0;
   logic [5:0] pri_lo = '0;
   logic       reti = 1'b0;
   logic       irq;
   logic [2:0] vec;
   int         errors = 0;
   int         checks = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   irq_prio_ctrl i_irq_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .flags_i(flags),
      .ie_all_i(ie_all), .ie_src_i(ie_src), .pri_hi_i(pri_hi),
      .pri_lo_i(pri_lo), .reti_i(reti), .irq_o(irq), .vec_o(vec)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_tick(output logic got, output logic [2:0] v);
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      got = irq; v = vec;
   endtask

   // encoded as 8 + index when a strobe is seen, 0 when none
   task automatic expect_vec(input string tag, input int exp_v);
      logic g; logic [2:0] v;
      do_tick(g, v);
      check(g === 1'b1 && int'(v) == exp_v, tag, g ? 8 + int'(v) : 0, 8 + exp_v);
   endtask

   task automatic expect_none(input string tag);
      logic g; logic [2:0] v;
      do_tick(g, v);
      check(g === 1'b0, tag, g ? 8 + int'(v) : 0, 0);
   endtask

   task automatic ret();
      @(negedge clk); reti = 1'b1;
      @(negedge clk); reti = 1'b0;
   endtask

   task automatic set_level(input int idx, input int lvl);
      pri_hi[idx] = lvl[1];
      pri_lo[idx] = lvl[0];
   endtask

   task automatic t_reset();
      check(irq === 1'b0, "R1 strobe", int'(irq), 0);
      check(vec === 3'd0, "R1 vector", int'(vec), 0);
      ie_all = 1'b1; ie_src = 6'h3F; flags = 8'h08;
      expect_vec("R1 first request taken", 3);
      ret();
   endtask

   task automatic t_global();
      ie_all = 1'b0; ie_src = 6'h3F; flags = 8'hFF;
      expect_none("R2 global off");
      ie_all = 1'b1;
   endtask

   task automatic t_mask();
      ie_src = 6'b001000; flags = 8'hFF;
      expect_vec("R3 only timer 1 enabled", 3);
      ret();
      ie_src = 6'b111011; flags = 8'h04;
      expect_none("R3 external 1 masked");
      ie_src = 6'h3F;
   endtask

   task automatic t_merge();
      flags = 8'h20;
      expect_vec("R4 transmit flag", 4); ret();
      flags = 8'h10;
      expect_vec("R4 receive flag", 4); ret();
      flags = 8'h80;
      expect_vec("R4 capture flag", 5); ret();
      flags = 8'h40;
      expect_vec("R4 overflow flag", 5); ret();
   endtask

   task automatic t_levels();
      flags = 8'hFF; set_level(5, 2);
      expect_vec("R5 level 2 beats level 0", 5); ret();
      set_level(3, 1); set_level(5, 1);
      expect_vec("R5 R6 tie at level 1", 3); ret();
      set_level(3, 0); set_level(5, 0);
   endtask

   task automatic t_poll();
      flags = 8'b0000_1110;
      expect_vec("R6 timer 0 first", 1); ret();
      flags = 8'b1011_0000;
      expect_vec("R6 serial before timer 2", 4); ret();
   endtask

   task automatic t_nest();
      set_level(2, 1); set_level(0, 1); set_level(4, 2);
      set_level(1, 3); set_level(3, 3);
      flags = 8'h04;
      expect_vec("R7 level 1 start", 2);
      flags = 8'h01;
      expect_none("R7 same level blocked");
      flags = 8'h10;
      expect_vec("R7 level 2 preempts", 4);
      flags = 8'h02;
      expect_vec("R7 level 3 preempts", 1);
      flags = 8'h08;
      expect_none("R7 level 3 not preempted");
      ret(); ret(); ret();
      pri_hi = '0; pri_lo = '0;
   endtask

   task automatic t_reti();
      set_level(1, 1);
      flags = 8'h02;
      expect_vec("R8 level 1 taken", 1);
      flags = 8'h02 | 8'h01;
      expect_none("R8 level 0 waits");
      ret();
      flags = 8'h01;
      expect_vec("R8 released, level 0 taken", 0);
      ret();
      pri_hi = '0; pri_lo = '0;
   endtask

   task automatic t_tick();
      int seen = 0;
      flags = 8'h04;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (irq) seen++;
      end
      check(seen == 0, "R9 no tick no strobe", seen, 0);
      expect_vec("R9 strobe after tick", 2);
      @(negedge clk);
      check(irq === 1'b0, "R9 strobe one cycle", int'(irq), 0);
      ret();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_global();
      t_mask();
      t_merge();
      t_levels();
      t_poll();
      t_nest();
      t_reti();
      t_tick();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule